// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A control byte, read at the moment a character is accepted, sets the frame shape: a character length of five to eight bits, one, one-and-a-half or two stop bits, and an optional parity bit that can be odd, even or held at a fixed level. A separate control bit pulls the line low at any time to send a break. Bit timing comes from an external tick that pulses sixteen times per bit period. The block has no divisor, no storage beyond the character in flight, and no status beyond its busy flag.

Characters enter over a valid/ready handshake. The transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole frame, so an upstream source sees back-pressure from the cycle after acceptance until the last stop period ends. While `in_ready` is low, a source may hold `in_valid` and `in_data` at any value, and none of it is taken. The control byte and the tick are plain level inputs.

Top module: `uart_tx_core`

## Requirements
- R1: After reset and whenever no frame is in progress and the break bit is clear, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: An accepted frame starts with one start bit at level 0, then the character least significant bit first. `line_ctrl[1:0]` gives the length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Each of these bits lasts 16 ticks.
- R3: Stop bits are at level 1. With `line_ctrl[2]`=0 there is one, lasting 16 ticks. With `line_ctrl[2]`=1 there are two (32 ticks), except for a 5-bit length, where the stop period is one and a half bits (24 ticks).
- R4: With `line_ctrl[3]`=1 a 16-tick parity bit sits between the last data bit and the stop period. With `line_ctrl[3]`=0 there is no parity bit.
- R5: With parity on and `line_ctrl[5]`=0, `line_ctrl[4]`=0 makes the count of ones across the sent data bits and the parity bit odd, and `line_ctrl[4]`=1 makes it even.
- R6: With parity on and `line_ctrl[5]`=1, the parity bit is the inverse of `line_ctrl[4]`, whatever the data.
- R7: While `line_ctrl[6]`=1, `tx_line` is 0 in the same cycle, and frame timing and `busy` carry on unchanged. Once the bit is cleared, the line shows the frame level again.
- R8: `line_ctrl[7]` has no effect on any frame.
- R9: The framing fields are sampled on the acceptance edge. A change to `line_ctrl[5:0]` during a frame does not alter that frame.
- R10: `in_ready` equals the inverse of `busy`. `busy` rises on the clock edge that accepts a character and falls on the edge that ends the last stop period. A character offered while `in_ready` is 0 is not accepted and does not disturb the frame in flight.
- R11: Frame progress moves only on clock edges where `baud_tick` is 1. With no tick, the line level and `busy` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken (idle) |
| in_data | input | 8 | Character, bit 0 sent first |
| line_ctrl | input | 8 | Framing control byte |
| baud_tick | input | 1 | One pulse per sixteenth of a bit |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
A wrong phase, bit index or tick count inside the block shows on `tx_line` within one bit period as a level in the wrong slot, or at the end of the frame as a `busy` fall that is early or late by whole ticks. A parity bit that was latched wrong shows only in the one parity slot, so every slot of every frame is compared against a level computed from the control byte. The sweep covers all sixty-four framing codes, several data values, sparse and stalled tick patterns, and mid-frame changes to the control byte, the break bit and the input handshake.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

  // Frame phase as seen on the line.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  // Length of the stop period.
  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_e;

  // Stop-period choice: the long setting on the shortest length gives 1.5 bits.
  function automatic stop_e pick_stop(input logic long_stop, input logic [1:0] len_code);
    if (!long_stop)            return STOP_ONE;
    else if (len_code == 2'b00) return STOP_ONE_HALF;
    else                       return STOP_TWO;
  endfunction

endpackage

// File: rtl/uart_tx_cfg_latch.sv
`timescale 1ns/1ps
module uart_tx_cfg_latch
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [7:0]        ctrl,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] data_q,
  output logic [IDX_W-1:0]  last_idx_q,
  output logic              par_on_q,
  output logic              par_bit_q,
  output stop_e             stop_sel_q
);

  logic [IDX_W-1:0]  last_idx_d;
  logic [DATA_W-1:0] sent_mask;
  logic              ones_odd;
  logic              par_bit_d;

  // Index of the final data bit: shortest length plus the two-bit code.
  assign last_idx_d = IDX_W'(MIN_LEN - 1) + IDX_W'(ctrl[1:0]);

  // Mask of bits that go out on the line; only these count for parity.
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sent_mask[g] = (IDX_W'(g) <= last_idx_d);
  end

  assign ones_odd = ^(data & sent_mask);

  // Stick mode: fixed level opposite the polarity bit.
  // Normal: polarity 1 -> even total, polarity 0 -> odd total.
  always_comb begin
    if (ctrl[5])     par_bit_d = ~ctrl[4];
    else if (ctrl[4]) par_bit_d = ones_odd;
    else             par_bit_d = ~ones_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      last_idx_q <= '0;
      par_on_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      stop_sel_q <= STOP_ONE;
    end else if (load) begin
      data_q     <= data;
      last_idx_q <= last_idx_d;
      par_on_q   <= ctrl[3];
      par_bit_q  <= par_bit_d;
      stop_sel_q <= pick_stop(ctrl[2], ctrl[1:0]);
    end
  end

  // R2: the latched length never falls below the shortest character
  assert_len_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (last_idx_q >= IDX_W'(MIN_LEN - 1)));

endmodule

// File: rtl/uart_tx_tick_timer.sv
`timescale 1ns/1ps
module uart_tx_tick_timer #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          period_end
);

  logic [CW-1:0] cnt;

  assign period_end = !restart && tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (period_end) cnt <= '0;
    else if (tick)       cnt <= cnt + CW'(1);
  end

  // R11: without a tick the count holds
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(cnt));

  // R11: the count stays inside the current period
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);

endmodule

// File: rtl/uart_tx_sequencer.sv
`timescale 1ns/1ps
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [DATA_W-1:0] data_q,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              par_on,
  input  logic              par_bit,
  output phase_e            phase,
  output logic              level
);

  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
    end else if (start) begin
      phase   <= PH_START;
      bit_idx <= '0;
    end else if (step) begin
      unique case (phase)
        PH_START: begin
          phase   <= PH_DATA;
          bit_idx <= '0;
        end
        PH_DATA: begin
          if (bit_idx == last_idx) phase <= par_on ? PH_PARITY : PH_STOP;
          else                     bit_idx <= bit_idx + IDX_W'(1);
        end
        PH_PARITY: phase <= PH_STOP;
        PH_STOP:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_START:  level = 1'b0;
      PH_DATA:   level = data_q[bit_idx];
      PH_PARITY: level = par_bit;
      default:   level = 1'b1;
    endcase
  end

  // R2: data bits advance one position at a time
  assert_data_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_DATA && bit_idx != $past(bit_idx))
      |-> bit_idx == $past(bit_idx) + IDX_W'(1));

  // R2: the data phase ends only after the configured last bit
  assert_data_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_DATA && (phase == PH_PARITY || phase == PH_STOP))
      |-> $past(bit_idx) == last_idx);

  // R4: the parity slot appears only when parity is enabled
  assert_parity_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_PARITY |-> par_on);

endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int MIN_LEN       = 5,
  localparam int IDX_W        = $clog2(DATA_W),
  localparam int CW           = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [7:0]        line_ctrl,
  input  logic              baud_tick,
  output logic              tx_line,
  output logic              busy
);

  localparam logic [CW-1:0] LIM_ONE  = CW'(TICKS_PER_BIT);
  localparam logic [CW-1:0] LIM_HALF = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CW-1:0] LIM_TWO  = CW'(2 * TICKS_PER_BIT);

  logic              accept;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic              par_on_q;
  logic              par_bit_q;
  stop_e             stop_sel_q;
  phase_e            phase;
  logic              level;
  logic              period_end;
  logic [CW-1:0]     limit;

  assign busy     = (phase != PH_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  uart_tx_cfg_latch #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .ctrl       (line_ctrl),
    .data       (in_data),
    .data_q     (data_q),
    .last_idx_q (last_idx_q),
    .par_on_q   (par_on_q),
    .par_bit_q  (par_bit_q),
    .stop_sel_q (stop_sel_q)
  );

  always_comb begin
    if (phase == PH_STOP) begin
      unique case (stop_sel_q)
        STOP_ONE_HALF: limit = LIM_HALF;
        STOP_TWO:      limit = LIM_TWO;
        default:       limit = LIM_ONE;
      endcase
    end else begin
      limit = LIM_ONE;
    end
  end

  uart_tx_tick_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (accept || !busy),
    .tick       (baud_tick),
    .limit      (limit),
    .period_end (period_end)
  );

  uart_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .step     (period_end),
    .data_q   (data_q),
    .last_idx (last_idx_q),
    .par_on   (par_on_q),
    .par_bit  (par_bit_q),
    .phase    (phase),
    .level    (level)
  );

  // Break forces the line low without touching frame timing.
  assign tx_line = level & ~line_ctrl[6];

  // R10: an accepted character makes the block busy on the next cycle
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R1: idle line is high unless break is set
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_ctrl[6]) |-> tx_line);

  // R9: latched framing stays frozen while a frame runs
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(last_idx_q) && $stable(par_on_q)
                        && $stable(par_bit_q) && $stable(stop_sel_q) && $stable(data_q))));

  // R3: the stop period is high on the line when break is clear
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && !line_ctrl[6]) |-> tx_line);

  // R11: a frame cannot end on a cycle without a tick
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> busy);

endmodule

// File: tb/test_uart_tx_core.sv
`timescale 1ns/1ps
module test_uart_tx_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [7:0] line_ctrl = 8'h00;
  logic       baud_tick = 1'b0;
  logic       tx_line;
  logic       busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_core i_uart_tx_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .line_ctrl (line_ctrl),
    .baud_tick (baud_tick),
    .tx_line   (tx_line),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected frame level for tick slot t (start, data, parity, stop).
  function automatic bit slot_level(int t, int nbits, bit pen, bit pbit, logic [7:0] d);
    if (t < 16) return 1'b0;
    if (t < 16 + 16 * nbits) return d[(t - 16) / 16];
    if (pen && t < 32 + 16 * nbits) return pbit;
    return 1'b1;
  endfunction

  function automatic string slot_tag(int t, int nbits, bit pen);
    if (t < 16 + 16 * nbits) return "R2";
    if (pen && t < 32 + 16 * nbits) return "R4/R5/R6";
    return "R3/R4";
  endfunction

  // tick_mode: 0 every cycle, 1 every third cycle, 2 stalled for 40 cycles then every cycle
  // disturb:   1 offer another character mid-frame, 2 change framing mid-frame, 4 break window
  task automatic run_frame(input logic [7:0] ctrl, input logic [7:0] d,
                           input int tick_mode, input int disturb, input string scen);
    int  nbits, stop_len, total, t, cf, ones, bad_t, bad_line, bad_busy, bt_act;
    bit  pen, pbit, exp_line, exp_busy, brk;
    logic [7:0] mask;
    nbits    = 5 + int'(ctrl[1:0]);
    pen      = ctrl[3];
    mask     = 8'hFF >> (8 - nbits);
    ones     = $countones(d & mask);
    if (ctrl[5])      pbit = !ctrl[4];
    else if (ctrl[4]) pbit = (ones % 2 == 1);
    else              pbit = (ones % 2 == 0);
    if (!ctrl[2])            stop_len = 16;
    else if (ctrl[1:0] == 0) stop_len = 24;
    else                     stop_len = 32;
    total = 16 + 16 * nbits + (pen ? 16 : 0) + stop_len;

    @(negedge clk);
    line_ctrl = ctrl;
    in_data   = d;
    in_valid  = 1'b1;
    baud_tick = 1'b1;
    @(posedge clk);            // accepting edge
    @(negedge clk);
    in_valid = 1'b0;
    t = 0; cf = 0; bad_line = -1; bad_busy = -1; bad_t = 0; bt_act = 0;
    for (int k = 0; k < 4000; k++) begin
      if ((disturb & 1) != 0) begin
        in_valid = (t >= 5 && t < 60);
        in_data  = ~d;
      end
      line_ctrl = ctrl & 8'hBF;
      if ((disturb & 2) != 0 && t >= 20)
        line_ctrl = {~ctrl[7], 1'b0, ~ctrl[5:0]};
      if ((disturb & 4) != 0 && t >= 30 && t < 50)
        line_ctrl[6] = 1'b1;
      brk = line_ctrl[6];
      #1;
      exp_busy = (t < total);
      exp_line = brk ? 1'b0 : (exp_busy ? slot_level(t, nbits, pen, pbit, d) : 1'b1);
      if (bad_line < 0 && tx_line !== exp_line) begin bad_line = t; bad_t = int'(exp_line); end
      if (bad_busy < 0 && (busy !== exp_busy || in_ready !== !exp_busy)) begin
        bad_busy = t; bt_act = int'(busy);
      end
      if (t >= total) break;
      case (tick_mode)
        1:       baud_tick = (cyc % 3 == 0);
        2:       baud_tick = (cf >= 40);
        default: baud_tick = 1'b1;
      endcase
      @(posedge clk);
      if (baud_tick) t++;
      cf++;
      @(negedge clk);
    end
    in_valid  = 1'b0;
    line_ctrl = ctrl & 8'hBF;
    check(bad_line < 0 && t >= total,
          {scen, " ", (bad_line >= 0) ? slot_tag(bad_line, nbits, pen) : "R2"},
          $sformatf("tx_line ctrl=%02h data=%02h tick slot %0d", ctrl, d, bad_line),
          (bad_line >= 0) ? 1 - bad_t : t, (bad_line >= 0) ? bad_t : total);
    check(bad_busy < 0,
          {scen, " R10"},
          $sformatf("busy ctrl=%02h data=%02h tick slot %0d (frame %0d ticks)",
                    ctrl, d, bad_busy, total),
          bt_act, (bad_busy >= 0 && bad_busy < total) ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(tx_line === 1'b1, "R1", "tx_line after reset", int'(tx_line), 1);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R11: idle with no tick and no offer stays idle
    baud_tick = 1'b0;
    repeat (10) @(negedge clk);
    check(busy === 1'b0 && tx_line === 1'b1, "R11", "idle without ticks",
          int'(busy), 0);

    // R2 R3 R4 R5 R6 R8: every framing code, four data values, bit 7 alternating
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] cc, dd;
        cc = {p[0], 1'b0, c[5:0]};
        dd = pats[p] ^ 8'(c * 37);
        run_frame(cc, dd, 0, 0, "sweep");
      end
    end

    // R8: same frame with bit 7 low and high
    run_frame(8'h1B, 8'h96, 0, 0, "R8 bit7=0");
    run_frame(8'h9B, 8'h96, 0, 0, "R8 bit7=1");

    // R11: sparse ticks and a stalled start
    for (int c = 0; c < 8; c++)
      run_frame(8'(c * 9), 8'(8'h5A + c * 29), 1, 0, "R11 sparse");
    run_frame(8'h0E, 8'hC3, 2, 0, "R11 stall");
    run_frame(8'h3C, 8'h81, 2, 0, "R11 stall");

    // R10: offers while busy are refused
    run_frame(8'h03, 8'h4D, 0, 1, "R10 offer-busy");
    run_frame(8'h08, 8'h10, 1, 1, "R10 offer-busy");

    // R9: framing changes mid-frame are ignored
    run_frame(8'h0C, 8'hE7, 0, 2, "R9 ctrl-change");
    run_frame(8'h33, 8'h29, 0, 2, "R9 ctrl-change");
    run_frame(8'h04, 8'h1F, 1, 2, "R9 ctrl-change");

    // R7: break window inside a frame, and break while idle
    run_frame(8'h1F, 8'hB4, 0, 4, "R7 break");
    run_frame(8'h2A, 8'hFF, 1, 6, "R7 break");
    @(negedge clk);
    line_ctrl = 8'h40;
    #1;
    check(tx_line === 1'b0, "R7", "break while idle", int'(tx_line), 0);
    line_ctrl = 8'h00;
    #1;
    check(tx_line === 1'b1, "R7", "break released while idle", int'(tx_line), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule